// File: doc/BRIEF.md
# Clock-Phase Lock Monitor

This block checks whether a free-running 64-state clock-generation counter keeps a fixed phase relative to a periodic external sync pulse. The sync pin is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector. On each detected edge the block samples the counter.

The block can average 1, 2, 4 or 8 samples into one measurement, which it reports in 6.2 fixed point. It declares lock once enough consecutive measurements are identical. If a locked measurement later moves, it clears lock and latches a loss flag.

Software controls the block through a small register interface: a control register, a status register and a phase readback register. It also reads two masked interrupt outputs.

Top module: `phase_lock_monitor`

## Requirements
- R1: After reset, every register reads 0x00 and both interrupt outputs are low.
- R2: A rise on `sync_in` counts as one sync event, however long the level stays high. The sample is taken from `phase_cnt` on the second clock edge after the first edge that sees the new level.
- R3: With averaging setting A = 0, each sync event loads the phase register (address 2) with the sampled state in bits [7:2] and 00 in bits [1:0].
- R4: With averaging setting A > 0, one measurement is made of 2^A sync events. The phase register changes only after the last of them, and then holds floor(sum × 4 / 2^A), an 8-bit value in 6.2 format.
- R5: Status bit 6 (locked) sets when the block completes 11 + A consecutive identical measurements.
- R6: A measurement that differs from the previous one while locked clears status bit 6 and sets status bit 7 (lost) in the same cycle.
- R7: Status bit 7 stays set until a write to the status register (address 1) with data bit 7 at 0. A new loss in the same cycle takes precedence over the clear.
- R8: `irq_lock` is status bit 6 gated by control bit 0, and `irq_lost` is status bit 7 gated by control bit 1. Each output falls when its status bit clears.
- R9: The control register is at address 0. Bit 7 enables the block and bits [5:4] hold A. While bit 7 is 0, sync events are ignored. Writing 0x80 enables the block with A = 0 and both interrupts masked.
- R10: Any write to the control register clears the phase register, the pending average, the match count and status bit 6. Status bit 7 is unaffected.
- R11: A mismatch before lock restarts the consecutive count, with the new measurement as the first of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that drives the phase counter and the monitor |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Asynchronous periodic sync pulse |
| phase_cnt | input | 6 | Current state of the clock-generation counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq_lock | output | 1 | Masked lock interrupt |
| irq_lost | output | 1 | Masked loss-of-lock interrupt |

## Verification
The assertions check the following relations on every cycle:
- a raised interrupt implies that its status bit is set;
- a lock that drops without a control write leaves the lost bit set;
- the lost bit persists unless a clearing write was made;
- the fraction reads zero when A is 0;
- the phase register holds still while the block is disabled;
- a control write unlocks the block.

Only the bench scenarios can show the following:
- the exact number of events needed to lock;
- the averaged 6.2 values;
- the restart of the run after an early mismatch;
- the precedence between a status clear and a new loss.

// File: rtl/plm_pkg.sv
package plm_pkg;
   localparam int ADDR_W        = 2;
   localparam int DATA_W        = 8;
   localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_PHASE = 2'd2;
   localparam int CTRL_EN_BIT    = 7;
   localparam int CTRL_AVG_LSB   = 4;
   localparam int CTRL_MLOST_BIT = 1;
   localparam int CTRL_MLOCK_BIT = 0;
   localparam int STAT_LOCK_BIT  = 6;
   localparam int STAT_LOST_BIT  = 7;

   typedef struct packed {
      logic       en;
      logic [1:0] avg;
      logic       mask_lost;
      logic       mask_lock;
   } ctrl_t;
endpackage

// File: rtl/plm_sync_edge.sv
module plm_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   initial begin
      if (STAGES < 2) $error("plm_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   genvar g;
   generate
      for (g = 0; g <= STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/plm_phase_avg.sv
module plm_phase_avg #(
   parameter int PHASE_W = 6,
   parameter int FRAC_W  = 2,
   parameter int AVG_W   = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        restart,
   input  logic                        sample_en,
   input  logic [PHASE_W-1:0]          phase_in,
   input  logic [AVG_W-1:0]            avg_sel,
   output logic                        meas_valid,
   output logic [PHASE_W+FRAC_W-1:0]   meas_val
);
   localparam int MAX_SHIFT = (1 << AVG_W) - 1;
   localparam int SUM_W     = PHASE_W + MAX_SHIFT;
   localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;
   localparam int SCL_W     = SUM_W + FRAC_W;

   initial begin
      if (AVG_W < 1 || AVG_W > 3) $error("plm_phase_avg: AVG_W out of range");
      if (FRAC_W < AVG_W)         $error("plm_phase_avg: FRAC_W too small");
   end

   logic [SUM_W-1:0] acc_q, sum_next;
   logic [CNT_W-1:0] cnt_q, last_idx;
   logic [SCL_W-1:0] scaled;

   always_comb begin
      last_idx = '0;
      for (int i = 0; i < CNT_W; i++) begin
         if (i < int'(avg_sel)) last_idx[i] = 1'b1;
      end
   end

   assign sum_next   = acc_q + SUM_W'(phase_in);
   assign scaled     = {sum_next, {FRAC_W{1'b0}}} >> avg_sel;
   assign meas_val   = scaled[PHASE_W+FRAC_W-1:0];
   assign meas_valid = sample_en && !restart && (cnt_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (restart || meas_valid) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (sample_en) begin
         acc_q <= sum_next;
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/plm_lock_track.sv
module plm_lock_track #(
   parameter int READ_W    = 8,
   parameter int AVG_W     = 2,
   parameter int LOCK_BASE = 11,
   parameter int CNT_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              meas_valid,
   input  logic [READ_W-1:0] meas_val,
   input  logic [AVG_W-1:0]  avg_sel,
   input  logic              lost_clr,
   output logic              locked,
   output logic              lost,
   output logic [READ_W-1:0] phase_q
);
   localparam int MAX_AVG = (1 << AVG_W) - 1;

   initial begin
      if (LOCK_BASE + MAX_AVG >= (1 << CNT_W))
         $error("plm_lock_track: CNT_W too narrow for lock target");
   end

   logic              have_ref;
   logic [CNT_W-1:0]  match_q, target;
   logic              same, lost_set;

   assign target   = CNT_W'(LOCK_BASE) + CNT_W'(avg_sel);
   assign same     = have_ref && (meas_val == phase_q);
   assign lost_set = meas_valid && !same && locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_ref <= 1'b0;
         match_q  <= '0;
         locked   <= 1'b0;
         phase_q  <= '0;
      end else if (restart) begin
         have_ref <= 1'b0;
         match_q  <= '0;
         locked   <= 1'b0;
         phase_q  <= '0;
      end else if (meas_valid) begin
         have_ref <= 1'b1;
         phase_q  <= meas_val;
         if (same) begin
            if (match_q != {CNT_W{1'b1}}) match_q <= match_q + 1'b1;
            if ((match_q + 1'b1) >= target) locked <= 1'b1;
         end else begin
            match_q <= CNT_W'(1);
            locked  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lost <= 1'b0;
      else if (lost_set) lost <= 1'b1;
      else if (lost_clr) lost <= 1'b0;
   end
endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor #(
   parameter int PHASE_W     = 6,
   parameter int FRAC_W      = 2,
   parameter int AVG_W       = 2,
   parameter int LOCK_BASE   = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sync_in,
   input  logic [PHASE_W-1:0]        phase_cnt,
   input  logic                      wr_en,
   input  logic [plm_pkg::ADDR_W-1:0] wr_addr,
   input  logic [plm_pkg::DATA_W-1:0] wr_data,
   input  logic [plm_pkg::ADDR_W-1:0] rd_addr,
   output logic [plm_pkg::DATA_W-1:0] rd_data,
   output logic                      irq_lock,
   output logic                      irq_lost
);
   import plm_pkg::*;

   localparam int READ_W = PHASE_W + FRAC_W;
   localparam int CNT_W  = $clog2(LOCK_BASE + (1 << AVG_W));

   initial begin
      if (READ_W != DATA_W) $error("phase_lock_monitor: readback must be DATA_W bits");
      if (AVG_W != 2)       $error("phase_lock_monitor: control layout holds a 2-bit average field");
   end

   ctrl_t             ctrl_q;
   logic              ctrl_wr, stat_clr, rise, meas_valid;
   logic [READ_W-1:0] meas_val, phase_q;
   logic              locked, lost;

   assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
   assign stat_clr = wr_en && (wr_addr == ADDR_STAT) && !wr_data[STAT_LOST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (ctrl_wr) begin
         ctrl_q.en        <= wr_data[CTRL_EN_BIT];
         ctrl_q.avg       <= wr_data[CTRL_AVG_LSB +: 2];
         ctrl_q.mask_lost <= wr_data[CTRL_MLOST_BIT];
         ctrl_q.mask_lock <= wr_data[CTRL_MLOCK_BIT];
      end
   end

   plm_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .async_in(sync_in), .rise_o(rise)
   );

   plm_phase_avg #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W), .AVG_W(AVG_W)) u_avg (
      .clk(clk), .rst_n(rst_n), .restart(ctrl_wr),
      .sample_en(rise && ctrl_q.en), .phase_in(phase_cnt),
      .avg_sel(ctrl_q.avg), .meas_valid(meas_valid), .meas_val(meas_val)
   );

   plm_lock_track #(.READ_W(READ_W), .AVG_W(AVG_W), .LOCK_BASE(LOCK_BASE), .CNT_W(CNT_W)) u_lock (
      .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .meas_valid(meas_valid),
      .meas_val(meas_val), .avg_sel(ctrl_q.avg), .lost_clr(stat_clr),
      .locked(locked), .lost(lost), .phase_q(phase_q)
   );

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         ADDR_CTRL: begin
            rd_data[CTRL_EN_BIT]            = ctrl_q.en;
            rd_data[CTRL_AVG_LSB +: 2]      = ctrl_q.avg;
            rd_data[CTRL_MLOST_BIT]         = ctrl_q.mask_lost;
            rd_data[CTRL_MLOCK_BIT]         = ctrl_q.mask_lock;
         end
         ADDR_STAT: begin
            rd_data[STAT_LOCK_BIT] = locked;
            rd_data[STAT_LOST_BIT] = lost;
         end
         ADDR_PHASE: rd_data = phase_q;
         default:    rd_data = '0;
      endcase
   end

   assign irq_lock = locked && ctrl_q.mask_lock;
   assign irq_lost = lost && ctrl_q.mask_lost;
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
   parameter int READ_W = 8,
   parameter int FRAC_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_wr,
   input logic              stat_clr,
   input logic              enable,
   input logic [1:0]        avg_sel,
   input logic              locked,
   input logic              lost,
   input logic [READ_W-1:0] phase_q,
   input logic              irq_lock,
   input logic              irq_lost
);
   a_r8_irq_lock_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lock |-> locked);
   a_r8_irq_lost_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lost |-> lost);
   a_r6_drop_sets_lost: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(locked) && !locked && !$past(ctrl_wr)) |-> lost);
   a_r7_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lost) && !$past(stat_clr)) |-> lost);
   a_r3_frac_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (avg_sel == 2'd0) |-> (phase_q[FRAC_W-1:0] == '0));
   a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !ctrl_wr) |=> $stable(phase_q));
   a_r10_write_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> !locked);
endmodule

bind phase_lock_monitor plm_checker #(.READ_W(READ_W), .FRAC_W(FRAC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_clr(stat_clr),
   .enable(ctrl_q.en), .avg_sel(ctrl_q.avg), .locked(locked), .lost(lost),
   .phase_q(phase_q), .irq_lock(irq_lock), .irq_lost(irq_lost)
);

// File: tb/tb_phase_lock_monitor.sv
module tb_phase_lock_monitor;
   logic       clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0, wr_en = 1'b0;
   logic [5:0] phase_cnt = '0;
   logic [1:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0, rd_data;
   logic       irq_lock, irq_lost;
   int checks = 0, errors = 0;
   bit done = 0;

   phase_lock_monitor dut (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .phase_cnt(phase_cnt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_lock(irq_lock), .irq_lost(irq_lost)
   );

   always #4 clk = ~clk;

   // behavioural reference model
   bit m_s1, m_s2, m_s3, m_en, m_ml, m_mo, m_locked, m_lost, m_have;
   int m_avg, m_acc, m_n, m_mcnt, m_phase;

   always @(posedge clk) begin
      bit e;
      int meas;
      e = m_s2 && !m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_s3 = 0; m_en = 0; m_ml = 0; m_mo = 0;
         m_locked = 0; m_lost = 0; m_have = 0;
         m_avg = 0; m_acc = 0; m_n = 0; m_mcnt = 0; m_phase = 0;
      end else begin
         if (wr_en && wr_addr == 2'd1 && !wr_data[7]) m_lost = 0;
         if (wr_en && wr_addr == 2'd0) begin
            m_en = wr_data[7]; m_avg = wr_data[5:4];
            m_mo = wr_data[1]; m_ml = wr_data[0];
            m_acc = 0; m_n = 0; m_mcnt = 0; m_have = 0; m_locked = 0; m_phase = 0;
         end else if (e && m_en) begin
            m_acc += phase_cnt;
            m_n++;
            if (m_n == (1 << m_avg)) begin
               meas = ((m_acc * 4) >> m_avg) & 255;
               if (m_have && meas == m_phase) begin
                  if (m_mcnt < 15) m_mcnt++;
                  if (m_mcnt >= 11 + m_avg) m_locked = 1;
               end else begin
                  if (m_locked) m_lost = 1;
                  m_locked = 0;
                  m_mcnt = 1;
               end
               m_have = 1; m_phase = meas; m_acc = 0; m_n = 0;
            end
         end
      end
   end

   function automatic logic [7:0] m_read(input logic [1:0] a);
      case (a)
         2'd0: return {m_en, 1'b0, m_avg[1:0], 2'b00, m_mo, m_ml};
         2'd1: return {m_lost, m_locked, 6'd0};
         2'd2: return m_phase[7:0];
         default: return 8'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
      end
   endtask

   // every-cycle comparison against the model (R2, R3, R4, R5, R6, R8)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(rd_addr == 2'd2 ? "R4 phase model" : rd_addr == 2'd1 ? "R6 status model" : "R9 ctrl model",
               rd_data, m_read(rd_addr));
         check("R8 irq_lock model", {7'd0, irq_lock}, {7'd0, m_locked && m_ml});
         check("R8 irq_lost model", {7'd0, irq_lost}, {7'd0, m_lost && m_mo});
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 0;
   endtask

   task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
      rd_addr = a;
      @(negedge clk);
      check(tag, rd_data, exp);
      tick();
   endtask

   task automatic pulse(input logic [5:0] ph, input int n = 1);
      phase_cnt = ph;
      repeat (n) begin
         sync_in = 1; tick(2);
         sync_in = 0; tick(6);
      end
   endtask

   initial begin
      tick(3);
      @(negedge clk);
      check("R1 reset irq", {6'd0, irq_lock, irq_lost}, 8'h00);
      rst_n = 1;
      tick();
      rd_chk("R1 reset ctrl", 2'd0, 8'h00);
      rd_chk("R1 reset status", 2'd1, 8'h00);
      rd_chk("R1 reset phase", 2'd2, 8'h00);

      // R5 lock after 11 events with A=0, interrupts unmasked
      wr(2'd0, 8'h83);
      pulse(6'd17, 10);
      rd_chk("R3 phase 17", 2'd2, 8'h44);
      rd_chk("R5 not locked after 10", 2'd1, 8'h00);
      // R2: a long high level counts once
      phase_cnt = 6'd17; sync_in = 1; tick(20); sync_in = 0; tick(6);
      rd_chk("R5 locked after 11", 2'd1, 8'h40);
      @(negedge clk); check("R8 irq_lock high", {7'd0, irq_lock}, 8'h01); tick();

      // R6 loss
      pulse(6'd20);
      rd_chk("R6 lost after move", 2'd1, 8'h80);
      @(negedge clk); check("R8 irq_lost high, lock low", {6'd0, irq_lock, irq_lost}, 8'h01); tick();
      rd_chk("R3 phase 20", 2'd2, 8'h50);

      // R7 clearing
      wr(2'd1, 8'h80);
      rd_chk("R7 write bit7=1 keeps lost", 2'd1, 8'h80);
      wr(2'd1, 8'h00);
      rd_chk("R7 write bit7=0 clears lost", 2'd1, 8'h00);
      @(negedge clk); check("R8 irq_lost falls", {7'd0, irq_lost}, 8'h00); tick();

      // R4 averaging A=2
      wr(2'd0, 8'hA3);
      rd_chk("R10 ctrl write clears phase", 2'd2, 8'h00);
      pulse(6'd10); pulse(6'd11); pulse(6'd10);
      rd_chk("R4 no update mid-average", 2'd2, 8'h00);
      pulse(6'd11);
      rd_chk("R4 average 10.5", 2'd2, 8'h2A);
      pulse(6'd20); pulse(6'd21); pulse(6'd21); pulse(6'd21);
      rd_chk("R4 average 20.75", 2'd2, 8'h53);

      // R9 disabled ignores syncs
      wr(2'd0, 8'h00);
      pulse(6'd30, 3);
      rd_chk("R9 disabled phase", 2'd2, 8'h00);
      rd_chk("R9 disabled status", 2'd1, 8'h00);

      // R11 restart after early mismatch, interrupts masked
      wr(2'd0, 8'h80);
      rd_chk("R9 ctrl readback 0x80", 2'd0, 8'h80);
      pulse(6'd5, 5);
      pulse(6'd6, 10);
      rd_chk("R11 run restarted, not locked", 2'd1, 8'h00);
      pulse(6'd6);
      rd_chk("R11 locked after restarted run", 2'd1, 8'h40);
      @(negedge clk); check("R8 masked irq low", {6'd0, irq_lock, irq_lost}, 8'h00); tick();

      // R10 control write drops lock without lost
      wr(2'd0, 8'h80);
      rd_chk("R10 unlock without lost", 2'd1, 8'h00);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule